// File: doc/BRIEF.md
# Descriptor Ring Run Controller

This block sequences one direction of a descriptor-driven DMA engine. A level-sensitive run enable starts and stops the process, and a list base address tells it where to begin. The block holds a current-descriptor pointer that survives a stop, so a later restart picks up where the process left off. While running, it issues a fetch for the descriptor at the current pointer and waits for a response that carries the descriptor's ownership bit and the address of the next descriptor.

When the descriptor belongs to the DMA, the block marks a frame as in progress. When a frame-done pulse arrives, the pointer advances to the next descriptor. When the descriptor belongs to software, the block parks in a suspended state and raises a sticky buffer-unavailable flag. A poll pulse makes it fetch the same descriptor again.

A stop request never cuts off a frame in progress. It takes effect once that frame finishes, or at once when no frame is active. The block moves no data and has no memory of its own. It supplies the process state and the fetch address to the surrounding engine.

Top module: `dma_run_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, state_o is 2'b00 (stopped), fetch_req is 0, bu_flag is 0 and fetch_addr is 0.
- R2: When run_en is high in the stopped state, the next cycle shows state_o = 2'b01 (running) with fetch_req high and fetch_addr equal to the current position.
- R3: A base_wr pulse is accepted only in the stopped state, and the latest accepted value becomes the current position at the next start. Writes made while running or suspended are discarded. A start with no accepted write since the previous start resumes from the saved position. fetch_addr does not change while stopped.
- R4: A fetch answered by fetch_ack with fetch_own = 1 drops fetch_req the next cycle and starts a frame, and state_o stays 2'b01. After the frame_done pulse, with run_en still high, fetch_req rises again with fetch_addr equal to the fetch_next value captured with that descriptor.
- R5: A fetch answered with fetch_own = 0 leads to state_o = 2'b10 (suspended) and bu_flag = 1 in the next cycle, with fetch_addr unchanged.
- R6: Dropping run_en during a frame keeps state_o at 2'b01 until frame_done. In the cycle after frame_done, state_o is 2'b00 and fetch_addr holds the next-descriptor address.
- R7: Dropping run_en while suspended, or while a fetch is outstanding, gives state_o = 2'b00 in the next cycle with fetch_addr unchanged.
- R8: A poll pulse while suspended with run_en high returns the block to running, with a fetch of the same address. Without a poll, the suspended state holds. A poll in any other state has no effect.
- R9: bu_flag stays set until a bu_clr pulse clears it. When a new unowned descriptor arrives in the same cycle as bu_clr, the flag stays set.
- R10: state_o never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run command level: high to run, low to stop |
| base_wr | input | 1 | Strobe that loads base_addr as the list start |
| base_addr | input | ADDR_W | Descriptor list base address |
| poll | input | 1 | Pulse that re-fetches the current descriptor while suspended |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | ADDR_W | Address of the descriptor being fetched (current position) |
| fetch_ack | input | 1 | Fetch response valid |
| fetch_own | input | 1 | Ownership bit of the fetched descriptor (1 = DMA) |
| fetch_next | input | ADDR_W | Next-descriptor address from the fetched descriptor |
| frame_done | input | 1 | Pulse marking completion of the current frame |
| state_o | output | 2 | Process state: 00 stopped, 01 running, 10 suspended |
| bu_flag | output | 1 | Sticky buffer-unavailable flag |
| bu_clr | input | 1 | Write-one-to-clear for bu_flag |

## Verification
The hardest cases to reach are the pointer-retention paths. One is a stop that lands in the middle of a frame, and then the restart that follows without any new base write. The other is a base address written while running, which must be lost. Directed sequences step the block through each of these. A sweep then walks every ownership pattern of a four-descriptor chain. For each pattern it computes arithmetically the descriptor where suspension must occur, or the address saved after the final frame.

// File: rtl/dlrc_pkg.sv
package dlrc_pkg;

    typedef enum logic [1:0] {
        PH_STOP  = 2'd0,
        PH_FETCH = 2'd1,
        PH_XFER  = 2'd2,
        PH_SUSP  = 2'd3
    } phase_e;

    localparam logic [1:0] RS_STOPPED   = 2'b00;
    localparam logic [1:0] RS_RUNNING   = 2'b01;
    localparam logic [1:0] RS_SUSPENDED = 2'b10;

    typedef struct packed {
        logic start;    // load current position at a start
        logic capture;  // latch next pointer from an owned descriptor
        logic advance;  // frame finished: move to next pointer
    } ptr_cmd_t;

    function automatic logic [1:0] phase_to_state(phase_e p);
        case (p)
            PH_STOP:  return RS_STOPPED;
            PH_SUSP:  return RS_SUSPENDED;
            default:  return RS_RUNNING;
        endcase
    endfunction

endpackage

// File: rtl/dlrc_fsm.sv
module dlrc_fsm
    import dlrc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_en,
    input  logic     poll,
    input  logic     fetch_ack,
    input  logic     fetch_own,
    input  logic     frame_done,
    output phase_e   phase,
    output ptr_cmd_t cmd,
    output logic     bu_set
);

    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        cmd      = '0;
        bu_set   = 1'b0;
        case (phase)
            PH_STOP: begin
                if (run_en) begin
                    phase_nx  = PH_FETCH;
                    cmd.start = 1'b1;
                end
            end
            PH_FETCH: begin
                if (!run_en) begin
                    phase_nx = PH_STOP;
                end else if (fetch_ack) begin
                    if (fetch_own) begin
                        phase_nx    = PH_XFER;
                        cmd.capture = 1'b1;
                    end else begin
                        phase_nx = PH_SUSP;
                        bu_set   = 1'b1;
                    end
                end
            end
            PH_XFER: begin
                if (frame_done) begin
                    cmd.advance = 1'b1;
                    phase_nx    = run_en ? PH_FETCH : PH_STOP;
                end
            end
            PH_SUSP: begin
                if (!run_en)   phase_nx = PH_STOP;
                else if (poll) phase_nx = PH_FETCH;
            end
            default: phase_nx = PH_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_STOP;
        else     phase <= phase_nx;
    end

endmodule

// File: rtl/dlrc_ptr.sv
module dlrc_ptr
    import dlrc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stopped,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_addr,
    input  ptr_cmd_t          cmd,
    input  logic [ADDR_W-1:0] next_in,
    output logic [ADDR_W-1:0] cur_ptr
);

    logic [ADDR_W-1:0] pend_addr;
    logic              pend_vld;
    logic [ADDR_W-1:0] link_ptr;
    logic              wr_ok;

    assign wr_ok = base_wr && stopped;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_addr <= '0;
            pend_vld  <= 1'b0;
            link_ptr  <= '0;
            cur_ptr   <= '0;
        end else begin
            if (cmd.start) begin
                if (wr_ok)         cur_ptr <= base_addr;
                else if (pend_vld) cur_ptr <= pend_addr;
                pend_vld <= 1'b0;
            end else if (wr_ok) begin
                pend_addr <= base_addr;
                pend_vld  <= 1'b1;
            end
            if (cmd.capture) link_ptr <= next_in;
            if (cmd.advance) cur_ptr  <= link_ptr;
        end
    end

endmodule

// File: rtl/dlrc_flag.sv
module dlrc_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

endmodule

// File: rtl/dma_run_ctrl.sv
module dma_run_ctrl
    import dlrc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              poll,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    input  logic              fetch_own,
    input  logic [ADDR_W-1:0] fetch_next,
    input  logic              frame_done,
    output logic [1:0]        state_o,
    output logic              bu_flag,
    input  logic              bu_clr
);

    phase_e   phase;
    ptr_cmd_t cmd;
    logic     bu_set;

    dlrc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .poll       (poll),
        .fetch_ack  (fetch_ack),
        .fetch_own  (fetch_own),
        .frame_done (frame_done),
        .phase      (phase),
        .cmd        (cmd),
        .bu_set     (bu_set)
    );

    dlrc_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .stopped   (phase == PH_STOP),
        .base_wr   (base_wr),
        .base_addr (base_addr),
        .cmd       (cmd),
        .next_in   (fetch_next),
        .cur_ptr   (fetch_addr)
    );

    dlrc_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (bu_set),
        .clr_i  (bu_clr),
        .flag_o (bu_flag)
    );

    assign fetch_req = (phase == PH_FETCH);
    assign state_o   = phase_to_state(phase);

endmodule

// File: rtl/dlrc_checker.sv
module dlrc_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              run_en,
    input logic              poll,
    input logic              fetch_req,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_ack,
    input logic              fetch_own,
    input logic              frame_done,
    input logic [1:0]        state_o,
    input logic              bu_flag,
    input logic              bu_clr
);

    logic unowned_hit;
    assign unowned_hit = fetch_req && fetch_ack && !fetch_own && run_en;

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (state_o == 2'b00 && !fetch_req && !bu_flag));

    assert_start_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && run_en) |=> (state_o == 2'b01 && fetch_req));

    assert_idle_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && !run_en) |=> $stable(fetch_addr));

    assert_suspend_R5: assert property (@(posedge clk) disable iff (rst)
        unowned_hit |=> (state_o == 2'b10 && bu_flag && $stable(fetch_addr)));

    assert_frame_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b01 && !fetch_req && !frame_done) |=> (state_o == 2'b01 && !fetch_req));

    assert_susp_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10 && !run_en) |=> state_o == 2'b00);

    assert_susp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b10 && run_en && !poll) |=> (state_o == 2'b10 && $stable(fetch_addr)));

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (bu_flag && !bu_clr) |=> bu_flag);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (bu_clr && !unowned_hit) |=> !bu_flag);

    assert_state_code_R10: assert property (@(posedge clk) disable iff (rst)
        state_o != 2'b11);

endmodule

bind dma_run_ctrl dlrc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .poll       (poll),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .fetch_ack  (fetch_ack),
    .fetch_own  (fetch_own),
    .frame_done (frame_done),
    .state_o    (state_o),
    .bu_flag    (bu_flag),
    .bu_clr     (bu_clr)
);

// File: tb/tb_dma_run_ctrl.sv
module tb_dma_run_ctrl;

    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run_en = 1'b0;
    logic              base_wr = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              poll = 1'b0;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_ack = 1'b0;
    logic              fetch_own = 1'b0;
    logic [ADDR_W-1:0] fetch_next = '0;
    logic              frame_done = 1'b0;
    logic [1:0]        state_o;
    logic              bu_flag;
    logic              bu_clr = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    dma_run_ctrl #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .run_en(run_en), .base_wr(base_wr),
        .base_addr(base_addr), .poll(poll), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .fetch_own(fetch_own),
        .fetch_next(fetch_next), .frame_done(frame_done), .state_o(state_o),
        .bu_flag(bu_flag), .bu_clr(bu_clr)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        base_wr    = 1'b0;
        poll       = 1'b0;
        fetch_ack  = 1'b0;
        frame_done = 1'b0;
        bu_clr     = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        step();
        // R1 reset state
        chk("R1 state", state_o, 2'b00);
        chk("R1 req", fetch_req, 1'b0);
        chk("R1 flag", bu_flag, 1'b0);
        chk("R1 addr", fetch_addr, 0);
        rst = 1'b0;
        step();
        chk("R1 state after release", state_o, 2'b00);

        // R3 base write while stopped, then R2 start
        base_wr = 1'b1; base_addr = 16'h0040;
        step();
        chk("R3 addr stable while stopped", fetch_addr, 0);
        run_en = 1'b1;
        step();
        chk("R2 state", state_o, 2'b01);
        chk("R2 req", fetch_req, 1'b1);
        chk("R2 addr is base", fetch_addr, 16'h0040);

        // R4 owned descriptor
        fetch_ack = 1'b1; fetch_own = 1'b1; fetch_next = 16'h0050;
        step();
        chk("R4 req low in frame", fetch_req, 1'b0);
        chk("R4 running", state_o, 2'b01);
        poll = 1'b1;                       // R8 poll outside suspended ignored
        base_wr = 1'b1; base_addr = 16'h0099; // R3 write while running ignored
        step();
        step();
        chk("R8 poll ignored in frame", fetch_req, 1'b0);
        frame_done = 1'b1;
        step();
        chk("R4 refetch", fetch_req, 1'b1);
        chk("R4 next addr", fetch_addr, 16'h0050);

        // R5 unowned descriptor
        fetch_ack = 1'b1; fetch_own = 1'b0;
        step();
        chk("R5 suspended", state_o, 2'b10);
        chk("R5 flag", bu_flag, 1'b1);
        chk("R5 addr", fetch_addr, 16'h0050);
        step(); step();
        chk("R8 suspended holds", state_o, 2'b10);
        chk("R9 flag sticky", bu_flag, 1'b1);
        bu_clr = 1'b1;
        step();
        chk("R9 flag cleared", bu_flag, 1'b0);
        poll = 1'b1;
        step();
        chk("R8 poll resumes", state_o, 2'b01);
        chk("R8 refetch req", fetch_req, 1'b1);
        chk("R8 same addr", fetch_addr, 16'h0050);

        // R6 stop waits for frame end
        fetch_ack = 1'b1; fetch_own = 1'b1; fetch_next = 16'h0060;
        step();
        run_en = 1'b0;
        step(); step();
        chk("R6 still running", state_o, 2'b01);
        frame_done = 1'b1;
        step();
        chk("R6 stopped", state_o, 2'b00);
        chk("R6 saved addr", fetch_addr, 16'h0060);

        // R3 resume from saved position (running write discarded)
        run_en = 1'b1;
        step();
        chk("R3 resume addr", fetch_addr, 16'h0060);
        // R7 stop during outstanding fetch
        run_en = 1'b0;
        step();
        chk("R7 stop in fetch", state_o, 2'b00);
        chk("R7 addr kept", fetch_addr, 16'h0060);

        // R3 latest write wins
        base_wr = 1'b1; base_addr = 16'h0020;
        step();
        base_wr = 1'b1; base_addr = 16'h0024;
        step();
        run_en = 1'b1;
        step();
        chk("R3 latest base", fetch_addr, 16'h0024);
        fetch_ack = 1'b1; fetch_own = 1'b0;
        step();
        run_en = 1'b0;
        step();
        chk("R7 stop from suspended", state_o, 2'b00);
        chk("R7 addr kept susp", fetch_addr, 16'h0024);

        // R9 set wins over clear
        bu_clr = 1'b1;
        step();
        run_en = 1'b1;
        step();
        fetch_ack = 1'b1; fetch_own = 1'b0; bu_clr = 1'b1;
        step();
        chk("R9 set over clear", bu_flag, 1'b1);
        run_en = 1'b0;
        step();
        bu_clr = 1'b1;
        step();

        // Sweep of ownership patterns over a 4-descriptor chain
        for (int p = 0; p < 16; p++) begin
            base_wr = 1'b1; base_addr = 16'h0100;
            step();
            run_en = 1'b1;
            step();
            for (int i = 0; i < 4; i++) begin
                logic [ADDR_W-1:0] ea;
                ea = 16'h0100 + 16'(4 * i);
                chk("R4 sweep fetch req", fetch_req, 1'b1);
                chk("R4 sweep addr", fetch_addr, ea);
                if (p[i]) begin
                    fetch_ack = 1'b1; fetch_own = 1'b1; fetch_next = ea + 16'd4;
                    step();
                    if (i == 3) run_en = 1'b0;
                    frame_done = 1'b1;
                    step();
                    if (i == 3) begin
                        chk("R6 sweep stopped", state_o, 2'b00);
                        chk("R6 sweep saved", fetch_addr, 16'h0110);
                    end
                end else begin
                    fetch_ack = 1'b1; fetch_own = 1'b0;
                    step();
                    chk("R5 sweep suspended", state_o, 2'b10);
                    chk("R5 sweep flag", bu_flag, 1'b1);
                    chk("R5 sweep addr", fetch_addr, ea);
                    run_en = 1'b0;
                    step();
                    chk("R7 sweep stopped", state_o, 2'b00);
                    chk("R10 code", {31'd0, state_o == 2'b11}, 0);
                    break;
                end
            end
            bu_clr = 1'b1;
            step();
        end

        summary();
    end

endmodule